// File: doc/BRIEF.md
# Perfect-Shuffle Butterfly Network

This block transforms a frame of sixteen complex samples through four identical columns. The columns are chained, and each one does two things. First it interleaves the two halves of its sixteen words. Then it passes each neighbouring pair of words through a butterfly node. Every node multiplies its first word by a fixed complex coefficient, and that coefficient depends on the node's column and on its position in the column. The node then returns the difference and the sum of that product with the second word. All arithmetic is signed 16-bit fixed point, rounded and saturated.

A whole frame is presented in one cycle, together with a valid flag. One frame can be accepted every cycle. A register stage follows each column, so the result of a frame leaves four cycles after it enters, together with a matching valid flag. A synchronous reset drops every frame still in flight.

Top module: `shuffle_butterfly_net`

## Requirements
- R1: While `rst` is high at a rising edge, every pipeline valid bit is cleared. As a result, `out_valid` is 0 after a reset edge, and frames that were in flight never appear.
- R2: A frame sampled with `in_valid`=1 at rising edge t appears on `out_data` with `out_valid`=1 after rising edge t+3, which is four cycles after it was presented. `out_valid` is high at no other time.
- R3: Each column first reorders its words. Input word i goes to position 2i when i<8, and input word i+8 goes to position 2i+1.
- R4: After that reordering, node j of a column takes u = word 2j and v = word 2j+1. It writes v − c·u to position 2j and v + c·u to position 2j+1, where c is that node's coefficient.
- R5: The complex product c·u is formed at full precision. Each of its parts has 2^13 added, is shifted right arithmetically by 14, and is then saturated to the 16-bit signed range.
- R6: Every real and imaginary part of v − c·u and v + c·u is saturated to the range −32768..32767.
- R7: Column s (s = 0 for the first column) node j uses coefficient W^k with k = (j·2^s) mod 8. Here W^k has real part round(16384·cos(πk/8)) and imaginary part −round(16384·sin(πk/8)), in Q1.14.
- R8: Four identical columns act in sequence. Frames presented on consecutive cycles are processed independently, at a throughput of one frame per cycle.
- R9: Word i occupies bits [32i+31:32i] of `in_data` and of `out_data`. The imaginary part sits in the upper 16 bits of the word and the real part in the lower 16 bits, both in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_data` as a frame to process |
| in_data | input | 512 | Sixteen complex input words, word i at bits [32i+31:32i] |
| out_valid | output | 1 | Marks `out_data` as a processed frame |
| out_data | output | 512 | Sixteen complex output words after the fourth column |

## Verification
The hardest cases to reach from the ports are saturation inside a node's product, and saturation in the later sums once a word has grown through earlier columns. Random data seldom gets there. The stimulus therefore includes full-scale frames, with every part at +32767 or −32768 and with alternating signs, so that both the rounding clamp and the add/subtract clamp are hit in several columns. A second hard case is a reset that lands while frames still sit in the pipeline. The bench raises `rst` during a back-to-back burst, keeps `in_valid` high, and confirms that no dropped frame ever emerges.

// File: rtl/shuffle_bfly_pkg.sv
package shuffle_bfly_pkg;

    localparam int LOG2_PTS = 4;
    localparam int NPTS     = 1 << LOG2_PTS;
    localparam int NCOLS    = LOG2_PTS;
    localparam int NNODES   = NPTS / 2;
    localparam int DW       = 16;
    localparam int CW       = 16;
    localparam int CFRAC    = 14;
    localparam int WORDW    = 2 * DW;
    localparam int BUSW     = NPTS * WORDW;
    localparam int ACCW     = DW + CW + 2;

    localparam logic signed [ACCW-1:0] SAT_MAX = ACCW'((1 <<< (DW - 1)) - 1);
    localparam logic signed [ACCW-1:0] SAT_MIN = -SAT_MAX - ACCW'(1);

    typedef struct packed {
        logic signed [DW-1:0] im;
        logic signed [DW-1:0] re;
    } cword_t;

    typedef struct packed {
        logic signed [CW-1:0] im;
        logic signed [CW-1:0] re;
    } coef_t;

    typedef cword_t [NPTS-1:0] cvec_t;

    // Which power of the root a node uses: k = (node * 2^col) mod NNODES
    function automatic int coef_index(input int col, input int node);
        return (node << col) % NNODES;
    endfunction

    // Q1.14 powers of exp(-j*pi/8); k in 0..7
    function automatic coef_t twiddle(input int k);
        coef_t c;
        case (k % NNODES)
            0: c = '{re:  16'sd16384, im:  16'sd0};
            1: c = '{re:  16'sd15137, im: -16'sd6270};
            2: c = '{re:  16'sd11585, im: -16'sd11585};
            3: c = '{re:  16'sd6270,  im: -16'sd15137};
            4: c = '{re:  16'sd0,     im: -16'sd16384};
            5: c = '{re: -16'sd6270,  im: -16'sd15137};
            6: c = '{re: -16'sd11585, im: -16'sd11585};
            7: c = '{re: -16'sd15137, im: -16'sd6270};
            default: c = '{re: 16'sd16384, im: 16'sd0};
        endcase
        return c;
    endfunction

    function automatic logic signed [DW-1:0] sat_word(input logic signed [ACCW-1:0] x);
        if (x > SAT_MAX)      return SAT_MAX[DW-1:0];
        else if (x < SAT_MIN) return SAT_MIN[DW-1:0];
        else                  return x[DW-1:0];
    endfunction

endpackage

// File: rtl/perfect_shuffle.sv
module perfect_shuffle
    import shuffle_bfly_pkg::*;
(
    input  cvec_t in_w,
    output cvec_t out_w
);

    // Interleave lower half with upper half
    for (genvar i = 0; i < NNODES; i++) begin : g_lane
        assign out_w[2*i]   = in_w[i];
        assign out_w[2*i+1] = in_w[i+NNODES];
    end

endmodule

// File: rtl/bfly_node.sv
module bfly_node
    import shuffle_bfly_pkg::*;
#(
    parameter coef_t C = '{re: 16'sd16384, im: 16'sd0}
) (
    input  cword_t u,
    input  cword_t v,
    output cword_t lo,
    output cword_t hi
);

    localparam logic signed [ACCW-1:0] CRE  = ACCW'($signed(C.re));
    localparam logic signed [ACCW-1:0] CIM  = ACCW'($signed(C.im));
    localparam logic signed [ACCW-1:0] HALF = ACCW'(1) <<< (CFRAC - 1);
    localparam bit UNIT_COEF = (C.re == 16'sd16384) && (C.im == 16'sd0);

    logic signed [ACCW-1:0] ur, ui, vr, vi;
    logic signed [ACCW-1:0] pr_acc, pim_acc;
    logic signed [DW-1:0]   p_re, p_im;

    always_comb begin
        ur = ACCW'($signed(u.re));
        ui = ACCW'($signed(u.im));
        vr = ACCW'($signed(v.re));
        vi = ACCW'($signed(v.im));
        pr_acc  = (CRE * ur - CIM * ui + HALF) >>> CFRAC;
        pim_acc = (CRE * ui + CIM * ur + HALF) >>> CFRAC;
        p_re = sat_word(pr_acc);
        p_im = sat_word(pim_acc);
        lo.re = sat_word(vr - ACCW'($signed(p_re)));
        lo.im = sat_word(vi - ACCW'($signed(p_im)));
        hi.re = sat_word(vr + ACCW'($signed(p_re)));
        hi.im = sat_word(vi + ACCW'($signed(p_im)));
    end

    // R4
    always_comb begin
        if (u == '0) begin
            node_zero_u_chk: assert (lo == v && hi == v);
        end
    end

    if (UNIT_COEF) begin : g_unit
        // R7
        always_comb begin
            node_unit_coef_chk: assert (
                hi.re == sat_word(ACCW'($signed(v.re)) + ACCW'($signed(u.re))) &&
                lo.im == sat_word(ACCW'($signed(v.im)) - ACCW'($signed(u.im))));
        end
    end

endmodule

// File: rtl/bfly_column.sv
module bfly_column
    import shuffle_bfly_pkg::*;
#(
    parameter int COL = 0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  cvec_t in_w,
    output logic  out_valid,
    output cvec_t out_w
);

    cvec_t shuf_w;
    cvec_t node_w;

    perfect_shuffle u_shuf (
        .in_w  (in_w),
        .out_w (shuf_w)
    );

    for (genvar j = 0; j < NNODES; j++) begin : g_node
        bfly_node #(
            .C (twiddle(coef_index(COL, j)))
        ) u_node (
            .u  (shuf_w[2*j]),
            .v  (shuf_w[2*j+1]),
            .lo (node_w[2*j]),
            .hi (node_w[2*j+1])
        );
    end

    // data needs no reset; only the valid bit does
    always_ff @(posedge clk) begin
        out_w <= node_w;
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    // R1
    col_reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R2
    col_valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));

endmodule

// File: rtl/shuffle_butterfly_net.sv
module shuffle_butterfly_net
    import shuffle_bfly_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [BUSW-1:0] in_data,
    output logic            out_valid,
    output logic [BUSW-1:0] out_data
);

    cvec_t col_w [NCOLS+1];
    logic  col_v [NCOLS+1];

    assign col_w[0] = cvec_t'(in_data);
    assign col_v[0] = in_valid;

    // R8: identical columns chained, one register stage each
    for (genvar s = 0; s < NCOLS; s++) begin : g_col
        bfly_column #(
            .COL (s)
        ) u_col (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (col_v[s]),
            .in_w      (col_w[s]),
            .out_valid (col_v[s+1]),
            .out_w     (col_w[s+1])
        );
    end

    assign out_data  = col_w[NCOLS];
    assign out_valid = col_v[NCOLS];

endmodule

// File: tb/shuffle_butterfly_net_test.sv
`timescale 1ns/1ps
module shuffle_butterfly_net_test;

    localparam int N = 16;
    localparam int BW = N * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [BW-1:0] in_data = '0;
    logic          out_valid;
    logic [BW-1:0] out_data;

    int errors = 0;
    int checks = 0;
    bit started = 1'b0;

    always #2 clk = ~clk;

    shuffle_butterfly_net uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int sat16(input int x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    // Behavioural reference for R3..R9
    function automatic logic [BW-1:0] ref_net(input logic [BW-1:0] d);
        int re[N], im[N], tr[N], ti[N];
        logic [BW-1:0] r;
        for (int i = 0; i < N; i++) begin
            re[i] = int'($signed(d[32*i +: 16]));
            im[i] = int'($signed(d[32*i+16 +: 16]));
        end
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < N/2; i++) begin
                tr[2*i] = re[i];     ti[2*i] = im[i];
                tr[2*i+1] = re[i+8]; ti[2*i+1] = im[i+8];
            end
            for (int j = 0; j < N/2; j++) begin
                int k, cr, ci, pr, pq;
                k  = (j * (1 << s)) % 8;
                cr = $rtoi($floor(16384.0 * $cos(3.14159265358979 * k / 8.0) + 0.5));
                ci = -$rtoi($floor(16384.0 * $sin(3.14159265358979 * k / 8.0) + 0.5));
                pr = sat16((cr * tr[2*j] - ci * ti[2*j] + 8192) >>> 14);
                pq = sat16((cr * ti[2*j] + ci * tr[2*j] + 8192) >>> 14);
                re[2*j]   = sat16(tr[2*j+1] - pr);
                im[2*j]   = sat16(ti[2*j+1] - pq);
                re[2*j+1] = sat16(tr[2*j+1] + pr);
                im[2*j+1] = sat16(ti[2*j+1] + pq);
            end
        end
        for (int i = 0; i < N; i++) begin
            r[32*i +: 16]    = re[i][15:0];
            r[32*i+16 +: 16] = im[i][15:0];
        end
        return r;
    endfunction

    // Expected-output delay line (four cycles of latency, R2)
    logic          mv [4] = '{default: 1'b0};
    logic [BW-1:0] md [4];

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < 4; k++) mv[k] <= 1'b0;
        end else begin
            for (int k = 3; k > 0; k--) begin
                mv[k] <= mv[k-1];
                md[k] <= md[k-1];
            end
            mv[0] <= in_valid;
            md[0] <= ref_net(in_data);
        end
    end

    always @(negedge clk) begin
        if (started) begin
            checks++;
            if (out_valid !== mv[3]) begin
                errors++;
                $display("FAIL R2/R1 out_valid: got %b expected %b", out_valid, mv[3]);
            end
            if (mv[3] === 1'b1) begin
                checks++;
                if (out_data !== md[3]) begin
                    errors++;
                    for (int i = 0; i < N; i++) begin
                        if (out_data[32*i +: 32] !== md[3][32*i +: 32]) begin
                            $display("FAIL R3 R4 R5 R6 R7 R8 R9 word %0d: got %h expected %h",
                                     i, out_data[32*i +: 32], md[3][32*i +: 32]);
                            break;
                        end
                    end
                end
            end
        end
    end

    task automatic send(input logic [BW-1:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_data  = {N{32'hdead_beef}};
        end
    endtask

    function automatic logic [BW-1:0] rand_frame();
        logic [BW-1:0] f;
        for (int i = 0; i < N; i++) f[32*i +: 32] = $urandom;
        return f;
    endfunction

    function automatic logic [BW-1:0] fill(input logic [15:0] r, input logic [15:0] q);
        logic [BW-1:0] f;
        for (int i = 0; i < N; i++) f[32*i +: 32] = {q, r};
        return f;
    endfunction

    initial begin
        logic [BW-1:0] f;
        @(posedge clk);
        started = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset out_valid: got %b expected 0", out_valid);
        end
        rst = 1'b0;

        // R3 R4 R9: impulse in word 0, then in word 9
        f = '0; f[15:0] = 16'd1000;
        send(f);
        f = '0; f[32*9 +: 32] = {16'sd300, -16'sd700};
        send(f);
        send('0);
        idle(6);

        // R7 R8: DC frame, then a ramp
        send(fill(16'd100, 16'd0));
        for (int i = 0; i < N; i++) f[32*i +: 32] = {16'(i * 50), 16'(i * 37 - 200)};
        send(f);
        idle(6);

        // R5 R6: full-scale, alternating signs
        send(fill(16'h7fff, 16'h8000));
        send(fill(16'h8000, 16'h8000));
        for (int i = 0; i < N; i++) f[32*i +: 32] = (i % 2) ? {16'h7fff, 16'h8000} : {16'h8000, 16'h7fff};
        send(f);
        idle(6);

        // R8: back-to-back random burst with gaps
        for (int n = 0; n < 40; n++) begin
            send(rand_frame());
            if (n % 7 == 6) idle(1);
        end
        idle(6);

        // R1: reset while frames are in flight, in_valid kept high
        for (int n = 0; n < 3; n++) send(rand_frame());
        @(negedge clk);
        rst = 1'b1;
        in_data = rand_frame();
        @(negedge clk);
        in_data = rand_frame();
        @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        idle(6);

        // R2: single frame after long idle
        send(rand_frame());
        idle(8);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule